// File: doc/BRIEF.md
# Ball Sprite Pixel Walker

This block produces the pixel stream for a small round ball sprite. A pulse or level on the start input requests one ball at a chosen top-left corner. The block then issues one screen coordinate per clock, each flagged by a valid strobe, so that a frame-buffer writer downstream can store a colour at that spot. A one-cycle completion pulse marks the end of the ball.

The sprite is a 5x5 square with its four corners removed, which leaves 21 pixels. The walk follows raster order and skips the corners without gaps, so a ball takes exactly 21 drawing cycles. The machine does not accept a new request until start has been seen low. A caller that holds start high therefore gets exactly one ball.

Top module: `ball_sprite_drawer`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, draw_o and done_o are low and the block is idle.
- R2: When idle with start_i low, draw_o stays low. When start_i is high at a rising clock edge in idle, draw_o is high in the very next cycle.
- R3: Once drawing begins, draw_o stays high for exactly 21 consecutive cycles, one pixel per clock.
- R4: Pixels come in raster order: rows 0 to 4 from top to bottom, columns ascending within a row. Rows 0 and 4 cover columns 1 to 3. Rows 1 to 3 cover columns 0 to 4. With draw_o high, x_o equals the captured x plus the column and y_o equals the captured y plus the row.
- R5: pos_x_i and pos_y_i are captured in the edge that accepts start_i. Changes to them during the walk do not alter the emitted coordinates.
- R6: done_o is high for exactly one cycle, in the cycle right after the last pixel, and draw_o is low in that cycle.
- R7: draw_o is never high while idle, while done_o is high, or while waiting for start_i to fall.
- R8: If start_i is still high when done_o is high, no further ball begins until start_i has been low at a rising edge. The next high level then starts a new ball.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to draw one ball |
| pos_x_i | input | COORD_W | Column of the sprite's top-left corner |
| pos_y_i | input | COORD_W | Row of the sprite's top-left corner |
| x_o | output | COORD_W | Column of the current pixel |
| y_o | output | COORD_W | Row of the current pixel |
| draw_o | output | 1 | Current pixel coordinate is valid |
| done_o | output | 1 | One-cycle pulse after the last pixel |

## Verification
Each result is due at a fixed cycle offset. The first pixel appears one cycle after the edge that samples start_i, the k-th pixel k cycles after that edge, and done_o one cycle after the 21st pixel. The return to idle takes one more edge after done_o once start_i is low. The bench drives inputs on the falling edge and samples on the next falling edge. Because of this, each expected value is compared exactly one register stage after its cause. The held-start case counts several idle sample points at which draw_o must stay low before start_i drops.

// File: rtl/ball_pkg.sv
package ball_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DRAW,
    ST_DONE,
    ST_WAIT_LOW
  } draw_state_e;
endpackage

// File: rtl/ball_row_span.sv
// Column range covered by one row of the corner-less square sprite.
module ball_row_span #(
  parameter int SIZE  = 5,
  parameter int IDX_W = $clog2(SIZE)
) (
  input  logic [IDX_W-1:0] row_i,
  output logic [IDX_W-1:0] first_col_o,
  output logic [IDX_W-1:0] last_col_o
);
  logic edge_row;
  assign edge_row    = (row_i == '0) || (row_i == IDX_W'(SIZE-1));
  assign first_col_o = edge_row ? IDX_W'(1) : '0;
  assign last_col_o  = edge_row ? IDX_W'(SIZE-2) : IDX_W'(SIZE-1);
endmodule

// File: rtl/ball_scan.sv
module ball_scan #(
  parameter int SIZE  = 5,
  parameter int IDX_W = $clog2(SIZE)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] row_o,
  output logic [IDX_W-1:0] col_o,
  output logic             last_o
);
  logic [IDX_W-1:0] row_q, col_q, row_nx;
  logic [IDX_W-1:0] first_cur, last_cur, first_nx, last_nx, first_top, last_top;

  assign row_nx = row_q + IDX_W'(1);

  ball_row_span #(.SIZE(SIZE), .IDX_W(IDX_W)) span_cur_i (
    .row_i(row_q), .first_col_o(first_cur), .last_col_o(last_cur));
  ball_row_span #(.SIZE(SIZE), .IDX_W(IDX_W)) span_nx_i (
    .row_i(row_nx), .first_col_o(first_nx), .last_col_o(last_nx));
  ball_row_span #(.SIZE(SIZE), .IDX_W(IDX_W)) span_top_i (
    .row_i('0), .first_col_o(first_top), .last_col_o(last_top));

  logic row_end;
  assign row_end = (col_q == last_cur);
  assign last_o  = row_end && (row_q == IDX_W'(SIZE-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
    end else if (load_i) begin
      row_q <= '0;
      col_q <= first_top;
    end else if (step_i) begin
      if (row_end) begin
        row_q <= row_nx;
        col_q <= first_nx;
      end else begin
        col_q <= col_q + IDX_W'(1);
      end
    end
  end

  assign row_o = row_q;
  assign col_o = col_q;

  logic unused_spans;
  assign unused_spans = ^{last_nx, last_top};
endmodule

// File: rtl/ball_ctrl.sv
module ball_ctrl
  import ball_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic last_i,
  output logic load_o,
  output logic step_o,
  output logic draw_o,
  output logic done_o
);
  draw_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_DRAW;
        load_o  = 1'b1;
      end
      ST_DRAW:     if (last_i) state_d = ST_DONE;
      ST_DONE:     state_d = start_i ? ST_WAIT_LOW : ST_IDLE;
      ST_WAIT_LOW: if (!start_i) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign draw_o = (state_q == ST_DRAW);
  assign step_o = draw_o;
  assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/ball_sprite_drawer.sv
module ball_sprite_drawer #(
  parameter int COORD_W = 10,
  parameter int SIZE    = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [COORD_W-1:0] pos_x_i,
  input  logic [COORD_W-1:0] pos_y_i,
  output logic [COORD_W-1:0] x_o,
  output logic [COORD_W-1:0] y_o,
  output logic               draw_o,
  output logic               done_o
);
  localparam int IDX_W = $clog2(SIZE);

  logic             load, step, last;
  logic [IDX_W-1:0] row, col;
  logic [COORD_W-1:0] base_x_q, base_y_q;

  ball_ctrl ctrl_i (
    .clk_i, .rst_ni, .start_i,
    .last_i(last), .load_o(load), .step_o(step),
    .draw_o, .done_o);

  ball_scan #(.SIZE(SIZE), .IDX_W(IDX_W)) scan_i (
    .clk_i, .rst_ni,
    .load_i(load), .step_i(step),
    .row_o(row), .col_o(col), .last_o(last));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_x_q <= '0;
      base_y_q <= '0;
    end else if (load) begin
      base_x_q <= pos_x_i;
      base_y_q <= pos_y_i;
    end
  end

  assign x_o = base_x_q + {{(COORD_W-IDX_W){1'b0}}, col};
  assign y_o = base_y_q + {{(COORD_W-IDX_W){1'b0}}, row};
endmodule

// File: rtl/ball_sprite_drawer_chk.sv
module ball_sprite_drawer_chk #(
  parameter int COORD_W = 10,
  parameter int SIZE    = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic [COORD_W-1:0] x_o,
  input logic [COORD_W-1:0] y_o,
  input logic               draw_o,
  input logic               done_o
);
  localparam int PIXELS = SIZE*SIZE - 4;
  localparam int CNT_W  = $clog2(PIXELS+1);

  logic [CNT_W-1:0] draw_cnt_q;
  logic             armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      draw_cnt_q <= '0;
      armed_q    <= 1'b1;
    end else begin
      if (draw_o)      draw_cnt_q <= draw_cnt_q + CNT_W'(1);
      else if (done_o) draw_cnt_q <= '0;
      if (!start_i)    armed_q <= 1'b1;
      else if (done_o) armed_q <= 1'b0;
    end
  end

  AST_DRAW_NEEDS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(draw_o) |-> $past(start_i)); // R2
  AST_PIXEL_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> draw_cnt_q == CNT_W'(PIXELS)); // R3
  AST_ROW_MONOTONIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (draw_o && $past(draw_o)) |-> (y_o == $past(y_o) || y_o == $past(y_o) + COORD_W'(1))); // R4
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_AFTER_DRAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(draw_o)); // R6
  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(draw_o && done_o)); // R7
  AST_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(draw_o) |-> $past(armed_q)); // R8
endmodule

bind ball_sprite_drawer ball_sprite_drawer_chk #(.COORD_W(COORD_W), .SIZE(SIZE)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .x_o(x_o), .y_o(y_o), .draw_o(draw_o), .done_o(done_o));

// File: tb/ball_sprite_drawer_tb_top.sv
module ball_sprite_drawer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int COORD_W    = 10;
  localparam int NVEC       = 4;
  // {x, y} start positions
  localparam logic [2*COORD_W-1:0] VEC [NVEC] = '{
    {10'd0,    10'd0},
    {10'd100,  10'd50},
    {10'd1018, 10'd762},
    {10'd37,   10'd500}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start = 1'b0;
  logic [COORD_W-1:0] px = '0, py = '0;
  logic [COORD_W-1:0] x, y;
  logic draw, done;
  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ball_sprite_drawer #(.COORD_W(COORD_W), .SIZE(5)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start),
    .pos_x_i(px), .pos_y_i(py),
    .x_o(x), .y_o(y), .draw_o(draw), .done_o(done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // Start is raised at the current falling edge; walks and checks 21 pixels then done.
  task automatic walk_ball(input logic [COORD_W-1:0] bx, input logic [COORD_W-1:0] by,
                           input bit perturb);
    int k = 0;
    start = 1'b1; px = bx; py = by;
    for (int r = 0; r < 5; r++) begin
      for (int c = 0; c < 5; c++) begin
        if ((r == 0 || r == 4) && (c == 0 || c == 4)) continue;
        @(negedge clk);
        chk(draw == 1'b1, "R3 draw", int'(draw), 1);
        chk(done == 1'b0, "R7 done during draw", int'(done), 0);
        chk(x == bx + COORD_W'(c), "R4 x", int'(x), int'(bx + COORD_W'(c)));
        chk(y == by + COORD_W'(r), "R4 y", int'(y), int'(by + COORD_W'(r)));
        if (perturb && k == 4) begin
          px = bx + 10'd200; py = by + 10'd99; // R5: must be ignored
        end
        k++;
      end
    end
    @(negedge clk);
    chk(done == 1'b1, "R6 done pulse", int'(done), 1);
    chk(draw == 1'b0, "R6 draw low at done", int'(draw), 0);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    chk(draw == 1'b0, "R1 draw in reset", int'(draw), 0);
    chk(done == 1'b0, "R1 done in reset", int'(done), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(draw == 1'b0 && done == 1'b0, "R1 after reset", int'({draw, done}), 0);

    // R2 idle with start low
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(draw == 1'b0, "R2 idle no draw", int'(draw), 0);
    end

    // Table walk: R2 R3 R4 R5 R6
    for (int v = 0; v < NVEC; v++) begin
      walk_ball(VEC[v][2*COORD_W-1:COORD_W], VEC[v][COORD_W-1:0], v == 0);
      start = 1'b0;
      @(negedge clk);
      chk(done == 1'b0, "R6 done one cycle", int'(done), 0);
      chk(draw == 1'b0, "R7 idle after done", int'(draw), 0);
    end

    // R8: start held high after done
    walk_ball(10'd300, 10'd200, 1'b0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(draw == 1'b0, "R8 no redraw while start high", int'(draw), 0);
      chk(done == 1'b0, "R7 wait state done low", int'(done), 0);
    end
    start = 1'b0;
    @(negedge clk);
    chk(draw == 1'b0, "R8 start low cycle", int'(draw), 0);
    walk_ball(10'd5, 10'd6, 1'b0);
    start = 1'b0;
    @(negedge clk);

    // R1: reset mid-draw
    start = 1'b1; px = 10'd40; py = 10'd40;
    repeat (4) @(negedge clk);
    chk(draw == 1'b1, "R3 drawing before reset", int'(draw), 1);
    rst_ni = 1'b0;
    start = 1'b0;
    #1;
    chk(draw == 1'b0 && done == 1'b0, "R1 async reset mid-draw", int'({draw, done}), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(draw == 1'b0, "R1 idle after reset", int'(draw), 0);
    walk_ball(10'd60, 10'd70, 1'b0);
    start = 1'b0;
    @(negedge clk);

    finish_run();
  end
endmodule